// File: doc/BRIEF.md
# Instruction-Mix Counting Analyzer

This block performs a static census of a stored machine program. It holds several program banks of 32-bit instruction words, walks one chosen bank from word address zero upward, one word per clock, and sorts every fetched word into one of eight instruction categories by its opcode. It never executes an instruction. Each category has its own counter, and a separate counter tallies every word that is not the end marker.

A run starts with a clear pulse. The clear pulse zeroes the address and all counters and latches the program number. The analyzer then steps on its own. It stops when it meets the end-marker word 0xC0001073, or after it has counted the last address of the bank. It raises `done` and holds every count until the next clear. Banks are loaded through a plain write port that takes effect only while clear is held.

Top module: `instr_mix_analyzer`

## Requirements
- R1: While running (clear low, done low), each clock edge processes the word at the current address of the latched bank and then advances the address by one word, starting from address 0 after clear.
- R2: The category is taken from opcode bits [6:0]: 0x13 gives 0 (immediate ALU), 0x33 gives 1 (register ALU), 0x03 gives 2 (load), 0x23 gives 3 (store), 0x63 gives 4 (branch), 0x6F with a nonzero rd gives 5 (call), and 0x67 gives 7 (indirect jump).
- R3: Reset or a clear cycle sets done to 0 and sets the total counter and all eight category counters to 0.
- R4: Each processed word that is not the end marker and has a recognised opcode increments exactly one category counter. Category i is read on `cat_counts[i*CNT_W +: CNT_W]`.
- R5: A word whose opcode is not listed in R2 increments only the total counter.
- R6: The total counter increments by one for every processed word that is not the end marker.
- R7: When the processed word equals 0xC0001073, done rises after that edge and is not counted. From then on, the address and all counters hold until the next clear.
- R8: Counters are ADDR_W+1 bits wide. If the last address (255 by default) is processed without an end marker, that word is counted and done rises on the same edge, so a total of 256 is reachable without overflow.
- R9: The bank write port stores `wr_data` at (`wr_bank`, `wr_addr`) only on edges where clear is high. Writes with clear low are ignored.
- R10: The program number is latched during clear. Changing `prog_sel` while running does not affect which bank is analysed.
- R11: Opcode 0x6F with rd (bits [11:7]) equal to zero is category 6 (plain jump), never category 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear and start of a new run; also enables bank writes |
| prog_sel | input | 2 | Program bank number, latched while clear is high |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 2 | Bank written |
| wr_addr | input | 8 | Word address written |
| wr_data | input | 32 | Instruction word written |
| done | output | 1 | Run finished; all state frozen |
| total_count | output | 9 | Count of processed non-marker words |
| cat_counts | output | 72 | Eight packed category counters, category i at bits [i*9 +: 9] |

## Verification
The bench builds the block with its default parameters: four banks of 256 words and 9-bit counters. With these values a bank with no end marker runs through all 256 addresses, so the counter reaches 256 and the stop at the last address is exercised. With four banks, changing the program number in mid-run can point at a different bank whose contents are known to differ. Directed words cover every opcode class, the rd split on the jump opcode, unknown opcodes, a near-marker word and a marker at address 0. Random fills with random marker positions cover the rest.

// File: rtl/imx_pkg.sv
package imx_pkg;
   localparam int NUM_CATS = 8;
   localparam int CAT_W    = $clog2(NUM_CATS);

   typedef enum logic [CAT_W-1:0] {
      CAT_IMM    = 3'd0,
      CAT_REG    = 3'd1,
      CAT_LOAD   = 3'd2,
      CAT_STORE  = 3'd3,
      CAT_BRANCH = 3'd4,
      CAT_CALL   = 3'd5,
      CAT_JUMP   = 3'd6,
      CAT_IJUMP  = 3'd7
   } cat_e;

   localparam logic [6:0] OPC_IMM    = 7'h13;
   localparam logic [6:0] OPC_REG    = 7'h33;
   localparam logic [6:0] OPC_LOAD   = 7'h03;
   localparam logic [6:0] OPC_STORE  = 7'h23;
   localparam logic [6:0] OPC_BRANCH = 7'h63;
   localparam logic [6:0] OPC_JL     = 7'h6F;
   localparam logic [6:0] OPC_JLR    = 7'h67;

   localparam logic [31:0] END_MARK  = 32'hC000_1073;
endpackage

// File: rtl/imx_classify.sv
module imx_classify
   import imx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   output cat_e              cat,
   output logic              hit
);
   logic [6:0]          opc;
   logic [4:0]          rd;
   logic [NUM_CATS-1:0] match;

   assign opc = word[6:0];
   assign rd  = word[11:7];

   // jump-family words raise both the call line and the plain-jump line
   // when rd is zero; the higher index (plain jump) must win
   always_comb begin
      match             = '0;
      match[CAT_IMM]    = (opc == OPC_IMM);
      match[CAT_REG]    = (opc == OPC_REG);
      match[CAT_LOAD]   = (opc == OPC_LOAD);
      match[CAT_STORE]  = (opc == OPC_STORE);
      match[CAT_BRANCH] = (opc == OPC_BRANCH);
      match[CAT_CALL]   = (opc == OPC_JL);
      match[CAT_JUMP]   = (opc == OPC_JL) && (rd == 5'd0);
      match[CAT_IJUMP]  = (opc == OPC_JLR);
   end

   // priority encoder, highest asserted index wins
   always_comb begin
      cat = CAT_IMM;
      for (int i = 0; i < NUM_CATS; i++) begin
         if (match[i]) cat = cat_e'(CAT_W'(i));
      end
   end

   assign hit = |match;
endmodule

// File: rtl/imx_bank_store.sv
module imx_bank_store #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_word [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == BANK_W'(b))) mem[wr_addr] <= wr_data;
      end

      assign bank_word[b] = mem[rd_addr];
   end

   assign rd_data = bank_word[rd_bank];
endmodule

// File: rtl/imx_counters.sv
module imx_counters
   import imx_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      step,
   input  logic                      hit,
   input  cat_e                      cat,
   output logic [NUM_CATS*CNT_W-1:0] cat_counts,
   output logic [CNT_W-1:0]          total
);
   logic [NUM_CATS-1:0] cat_en;

   // one-hot enable, empty for unknown opcodes
   assign cat_en = (step && hit) ? (NUM_CATS'(1) << cat) : '0;

   for (genvar c = 0; c < NUM_CATS; c++) begin : g_cat
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cnt_q <= '0;
         else if (clr)       cnt_q <= '0;
         else if (cat_en[c]) cnt_q <= cnt_q + 1'b1;
      end

      assign cat_counts[c*CNT_W +: CNT_W] = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    total <= '0;
      else if (clr)  total <= '0;
      else if (step) total <= total + 1'b1;
   end
endmodule

// File: rtl/instr_mix_analyzer.sv
module instr_mix_analyzer
   import imx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 4,
   parameter int CNT_W     = ADDR_W + 1,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic [BANK_W-1:0]         prog_sel,
   input  logic                      wr_en,
   input  logic [BANK_W-1:0]         wr_bank,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic                      done,
   output logic [CNT_W-1:0]          total_count,
   output logic [NUM_CATS*CNT_W-1:0] cat_counts
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   if (CNT_W < ADDR_W + 1) begin : g_bad_cnt
      $error("CNT_W too narrow to count a full bank");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be at least 2");
   end
   if (DATA_W < 12) begin : g_bad_data
      $error("DATA_W must cover opcode and rd fields");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [BANK_W-1:0] prog_q;
   logic [DATA_W-1:0] cur_word;
   logic              at_mark;
   logic              step;
   logic              hit;
   cat_e              cat;

   imx_bank_store #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_BANKS(NUM_BANKS)
   ) u_store (
      .clk    (clk),
      .wr_en  (wr_en && clear),
      .wr_bank(wr_bank),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_bank(prog_q),
      .rd_addr(addr_q),
      .rd_data(cur_word)
   );

   imx_classify #(.DATA_W(DATA_W)) u_class (
      .word(cur_word),
      .cat (cat),
      .hit (hit)
   );

   assign at_mark = (cur_word == DATA_W'(END_MARK));
   assign step    = !clear && !done && !at_mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         prog_q <= '0;
         done   <= 1'b0;
      end else if (clear) begin
         addr_q <= '0;
         prog_q <= prog_sel;
         done   <= 1'b0;
      end else if (!done) begin
         if (at_mark)                done   <= 1'b1;
         else if (addr_q == LAST_ADDR) done <= 1'b1;
         else                        addr_q <= addr_q + 1'b1;
      end
   end

   imx_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clear),
      .step      (step),
      .hit       (hit),
      .cat       (cat),
      .cat_counts(cat_counts),
      .total     (total_count)
   );
endmodule

// File: rtl/imx_checker.sv
module imx_checker #(
   parameter int ADDR_W   = 8,
   parameter int CNT_W    = 9,
   parameter int NUM_CATS = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      clear,
   input logic                      done,
   input logic [CNT_W-1:0]          total_count,
   input logic [NUM_CATS*CNT_W-1:0] cat_counts
);
   logic [NUM_CATS*CNT_W-1:0] prev_counts;
   logic [NUM_CATS-1:0]       moved;
   logic [CNT_W+3:0]          cat_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_counts <= '0;
      else        prev_counts <= cat_counts;
   end

   always_comb begin
      cat_sum = '0;
      for (int i = 0; i < NUM_CATS; i++) begin
         moved[i] = cat_counts[i*CNT_W +: CNT_W] != prev_counts[i*CNT_W +: CNT_W];
         cat_sum  = cat_sum + (CNT_W+4)'(cat_counts[i*CNT_W +: CNT_W]);
      end
   end

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (total_count == '0) && (cat_counts == '0) && !done); // R3

   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clear) |=> done && $stable(total_count) && $stable(cat_counts)); // R7

   AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !done) |=> (total_count == $past(total_count)) ||
                            (total_count == $past(total_count) + 1'b1)); // R6

   AST_ONE_CAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !done) |=> $onehot0(moved)); // R4

   AST_CAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cat_sum <= (CNT_W+4)'(total_count)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      total_count <= CNT_W'(1 << ADDR_W)); // R8
endmodule

bind instr_mix_analyzer imx_checker #(
   .ADDR_W  (ADDR_W),
   .CNT_W   (CNT_W),
   .NUM_CATS(imx_pkg::NUM_CATS)
) u_imx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .clear      (clear),
   .done       (done),
   .total_count(total_count),
   .cat_counts (cat_counts)
);

// File: tb/test_instr_mix_analyzer.sv
module test_instr_mix_analyzer;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 9;
   localparam logic [31:0] MARK = 32'hC000_1073;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        clear;
   logic [1:0]  prog_sel;
   logic        wr_en;
   logic [1:0]  wr_bank;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic        done;
   logic [8:0]  total_count;
   logic [71:0] cat_counts;

   instr_mix_analyzer i_instr_mix_analyzer (
      .clk(clk), .rst_n(rst_n), .clear(clear), .prog_sel(prog_sel),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .total_count(total_count), .cat_counts(cat_counts)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   logic [31:0] bmem [4][256];
   int exp_cnt [8];
   int exp_total;
   int exp_edges;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int classify(input logic [31:0] w);
      case (w[6:0])
         7'h13: return 0;
         7'h33: return 1;
         7'h03: return 2;
         7'h23: return 3;
         7'h63: return 4;
         7'h6F: return (w[11:7] == 5'd0) ? 6 : 5;
         7'h67: return 7;
         default: return 8;
      endcase
   endfunction

   function automatic logic [31:0] gen_word();
      logic [6:0] ops [10] = '{7'h13, 7'h33, 7'h03, 7'h23, 7'h63,
                               7'h6F, 7'h6F, 7'h67, 7'h0F, 7'h73};
      logic [31:0] w = $urandom;
      int k = int'($urandom % 10);
      w[6:0] = ops[k];
      if (k == 6) w[11:7] = 5'd0;
      if (w == MARK) w[31] = 1'b0;
      return w;
   endfunction

   task automatic write_word(input int b, input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = 2'(b); wr_addr = 8'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (clear) bmem[b][a] = d;
   endtask

   task automatic model(input int b);
      exp_total = 0;
      exp_edges = 256;
      foreach (exp_cnt[i]) exp_cnt[i] = 0;
      for (int i = 0; i < 256; i++) begin
         if (bmem[b][i] == MARK) begin
            exp_edges = i + 1;
            break;
         end
         exp_total++;
         if (classify(bmem[b][i]) < 8) exp_cnt[classify(bmem[b][i])]++;
      end
   endtask

   task automatic check_counts(input string tag);
      check(total_count == 9'(exp_total), {tag, " total"}, int'(total_count), exp_total);
      for (int i = 0; i < 8; i++)
         check(cat_counts[i*CW +: CW] == 9'(exp_cnt[i]), $sformatf("%s cat%0d", tag, i),
               int'(cat_counts[i*CW +: CW]), exp_cnt[i]);
   endtask

   task automatic run_bank(input int b, input bit swap_prog, input string tag);
      @(negedge clk);
      prog_sel = 2'(b); clear = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && total_count == 0 && cat_counts == '0, "R3 clear zeroes",
            int'(total_count), 0);
      clear = 1'b0;
      model(b);
      for (int e = 1; e <= exp_edges; e++) begin
         @(negedge clk);
         if (swap_prog && e == 2) prog_sel = 2'(b ^ 1);
         if (e == exp_edges - 1) check(done == 1'b0, {tag, " R1 still running"}, int'(done), 0);
         if (e == exp_edges) check(done == 1'b1, {tag, " R7/R8 done edge"}, int'(done), 1);
      end
      check_counts(tag);
      repeat (4) @(negedge clk);
      check(done == 1'b1, {tag, " R7 done held"}, int'(done), 1);
      check_counts({tag, " R7 frozen"});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] dir [12] = '{32'h00A00513, 32'h00B50633, 32'h0004A283, 32'h00112623,
                                32'h00B50463, 32'h008000EF, 32'h0080006F, 32'h00008067,
                                32'h00000000, 32'hFFFFFFFF, 32'h40001073, MARK};
      process::self().srandom(32'd1234);
      rst_n = 1'b0; clear = 1'b1; prog_sel = '0;
      wr_en = 1'b0; wr_bank = '0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R3 reset done", int'(done), 0);
      check(total_count == 0 && cat_counts == '0, "R3 reset counts", int'(total_count), 0);

      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 256; a++) write_word(b, a, gen_word());
      for (int a = 0; a < 12; a++) write_word(1, a, dir[a]);
      write_word(0, 40 + int'($urandom % 100), MARK);
      write_word(3, 0, MARK);

      // directed classes, rd split, unknown opcodes, near-marker word
      run_bank(1, 1'b0, "R2 R5 R11 directed");
      check(cat_counts[6*CW +: CW] == 9'd1 && cat_counts[5*CW +: CW] == 9'd1,
            "R11 jump vs call", int'(cat_counts[6*CW +: CW]), 1);
      check(total_count == 9'd11, "R5 unknowns in total", int'(total_count), 11);

      // writes with clear low are ignored
      wr_en = 1'b1; wr_bank = 2'd1; wr_addr = 8'd0; wr_data = MARK;
      @(negedge clk);
      wr_en = 1'b0;
      check(total_count == 9'd11, "R9 ignored write while done", int'(total_count), 11);
      run_bank(1, 1'b0, "R9 rerun after ignored write");

      // program number change mid-run
      run_bank(0, 1'b1, "R10 prog swap");
      // full bank with no marker
      run_bank(2, 1'b0, "R8 full bank");
      check(total_count == 9'd256, "R8 total 256", int'(total_count), 256);
      // marker at address 0
      run_bank(3, 1'b0, "R7 marker at 0");
      // write while clear high takes effect
      @(negedge clk); clear = 1'b1;
      write_word(3, 0, 32'h00100093);
      write_word(3, 1, MARK);
      run_bank(3, 1'b0, "R9 write in clear");
      check(cat_counts[0 +: CW] == 9'd1, "R9 written word counted", int'(cat_counts[0 +: CW]), 1);

      // random refills with random marker positions
      for (int r = 0; r < 4; r++) begin
         int b = r & 3;
         @(negedge clk); clear = 1'b1;
         for (int a = 0; a < 64; a++) write_word(b, a, gen_word());
         write_word(b, int'($urandom % 64), MARK);
         run_bank(b, r[0], $sformatf("R4 R6 random %0d", r));
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end
endmodule